// File: doc/BRIEF.md
# Hashed Four-Way SPI to SA Index Table

This block turns the security parameter index of an inbound IPsec packet into the index of its security association. The search key is made of three parts: the 32-bit SPI, a 16-bit match identifier and a 7-bit owner (logical function) identifier. Entries sit in a four-way set-associative table. Each way computes its own set index from the key, so one key has four candidate locations.

A command port accepts add, delete and flush-by-owner operations, one at a time, under a valid/ready handshake. Add and delete answer one cycle after acceptance with a status, the set index, the way and a duplicate flag. A flush steps through the sets one cycle at a time. During the walk it clears every entry owned by the given function, and it holds ready low until the walk is done. A separate lookup port takes a key and, one cycle later, reports hit or miss together with the stored SA index and the way.

Top module: `spi_sa_table`

## Requirements
- R1: After reset the table is empty, `cmd_ready_o` is high, `rsp_valid_o` and `lk_done_o` are low, and every lookup misses.
- R2: The key is the 55-bit word {owner[6:0], match[15:0], spi[31:0]} with spi in the low bits. It is zero-extended to a whole number of IDX_W-bit slices, and the slices are XORed together into a fold. The set index of way w is that fold rotated left by (w mod IDX_W). Every add response reports the index that belongs to its way.
- R3: An add whose key is not present takes the lowest-numbered way (0 first) whose candidate location has its valid bit clear. It answers status 0 (ok) with the duplicate flag clear, and `rsp_valid_o` is high in the cycle after acceptance.
- R4: When a candidate location already holds a valid entry with an equal spi, match and owner, an add writes nothing. It answers status 0 with that location's index and way and the duplicate flag set, and the duplicate check wins even when all four ways are occupied.
- R5: When all four candidate locations are valid and none is a duplicate, an add answers status 1 (full) with index 0 and way 0, and it writes nothing.
- R6: Delete (op 1) names an index and a way. When the stored owner equals the requester's owner, it zeroes the key and the value there and answers status 0, after which the location is free again.
- R7: A delete whose requester is not the stored owner answers status 2 and leaves the entry unchanged.
- R8: Flush (op 2) zeroes every entry whose owner equals the requester's and leaves entries of other owners in place. `cmd_ready_o` stays low for exactly 2^IDX_W cycles, followed by a single status-0 response.
- R9: A lookup presented in one cycle gives `lk_done_o` in the next cycle. `lk_hit_o`, `lk_way_o` and `lk_sa_o` report the way whose stored key is valid and equal to the lookup key. An entry added with the request's valid bit at 0 never hits and does not block later adds of the same key (op 0 is add).
- R10: Keys that differ only in their owner are distinct entries and never match as duplicates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Command can be accepted (low during a flush) |
| cmd_op_i | input | 2 | 0 add, 1 delete, 2 flush, 3 no operation |
| cmd_spi_i | input | 32 | SPI of the key (add) |
| cmd_mid_i | input | 16 | Match identifier of the key (add) |
| cmd_owner_i | input | 7 | Requesting owner identifier |
| cmd_vld_i | input | 1 | Valid bit written with an added entry |
| cmd_sa_i | input | SA_W | SA index to store (add) |
| cmd_idx_i | input | IDX_W | Set index (delete) |
| cmd_way_i | input | 2 | Way (delete) |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_status_o | output | 2 | 0 ok, 1 full, 2 not owner |
| rsp_idx_o | output | IDX_W | Set index used or found |
| rsp_way_o | output | 2 | Way used or found |
| rsp_dup_o | output | 1 | Add found an existing equal entry |
| lk_valid_i | input | 1 | Lookup request |
| lk_spi_i | input | 32 | Lookup SPI |
| lk_mid_i | input | 16 | Lookup match identifier |
| lk_owner_i | input | 7 | Lookup owner identifier |
| lk_done_o | output | 1 | Lookup result strobe |
| lk_hit_o | output | 1 | Lookup found a valid entry |
| lk_way_o | output | 2 | Way of the hit |
| lk_sa_o | output | SA_W | SA index of the hit |

## Verification
The hardest condition to reach from the ports is a set where all four candidate locations are taken, because each way hashes the key differently. Full, lowest-free-way selection and a duplicate found in a full set all depend on that condition. The stimulus relies on the fold being linear. Keys whose SPI carries the same value j in its lowest two IDX_W-bit slices fold to one value, so they share the same candidate location in every way. Four such keys fill one set, a fifth finds it full, and deleting the way-0 entry frees that location again for reuse.

// File: rtl/spi_sa_pkg.sv
package spi_sa_pkg;
  localparam int SPI_W = 32;
  localparam int MID_W = 16;
  localparam int OWN_W = 7;
  localparam int KEY_W = SPI_W + MID_W + OWN_W;

  typedef struct packed {
    logic             vld;
    logic [OWN_W-1:0] owner;
    logic [MID_W-1:0] mid;
    logic [SPI_W-1:0] spi;
  } sa_key_t;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_DEL   = 2'd1,
    OP_FLUSH = 2'd2,
    OP_NONE  = 2'd3
  } sa_op_e;

  typedef enum logic [1:0] {
    RS_OK        = 2'd0,
    RS_FULL      = 2'd1,
    RS_NOT_OWNER = 2'd2
  } sa_status_e;
endpackage

// File: rtl/spi_sa_hash.sv
module spi_sa_hash
  import spi_sa_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int WAYS  = 4
) (
  input  logic [KEY_W-1:0]            key_i,
  output logic [WAYS-1:0][IDX_W-1:0]  idx_o
);
  localparam int NSL = (KEY_W + IDX_W - 1) / IDX_W;

  logic [NSL*IDX_W-1:0] ext;
  logic [IDX_W-1:0]     fold;
  logic [2*IDX_W-1:0]   dbl;

  assign ext = {{(NSL*IDX_W-KEY_W){1'b0}}, key_i};

  always_comb begin
    fold = '0;
    for (int s = 0; s < NSL; s++) fold ^= ext[s*IDX_W +: IDX_W];
  end

  assign dbl = {fold, fold};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam int ROT = w % IDX_W;
    // rotate left by ROT
    assign idx_o[w] = dbl[2*IDX_W-1-ROT -: IDX_W];
  end
endmodule

// File: rtl/spi_sa_bank.sv
module spi_sa_bank
  import spi_sa_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int SA_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] c_idx_i,
  output sa_key_t          c_key_o,
  input  logic [IDX_W-1:0] l_idx_i,
  output sa_key_t          l_key_o,
  output logic [SA_W-1:0]  l_sa_o,
  input  logic             we_i,
  input  sa_key_t          w_key_i,
  input  logic [SA_W-1:0]  w_sa_i
);
  localparam int DEPTH = 1 << IDX_W;

  sa_key_t         key_q [DEPTH];
  logic [SA_W-1:0] sa_q  [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        key_q[i] <= '0;
        sa_q[i]  <= '0;
      end
    end else if (we_i) begin
      key_q[c_idx_i] <= w_key_i;
      sa_q[c_idx_i]  <= w_sa_i;
    end
  end

  assign c_key_o = key_q[c_idx_i];
  assign l_key_o = key_q[l_idx_i];
  assign l_sa_o  = sa_q[l_idx_i];
endmodule

// File: rtl/spi_sa_pick.sv
module spi_sa_pick
  import spi_sa_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  sa_key_t [WAYS-1:0] keys_i,
  input  logic [KEY_W-1:0]   req_i,
  output logic               dup_o,
  output logic [WAY_W-1:0]   dup_way_o,
  output logic               free_o,
  output logic [WAY_W-1:0]   free_way_o
);
  logic [WAYS-1:0] eq, empty;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w]    = keys_i[w].vld && (keys_i[w][KEY_W-1:0] == req_i);
    assign empty[w] = !keys_i[w].vld;
  end

  // lowest index wins for both searches
  always_comb begin
    dup_o = 1'b0; dup_way_o = '0;
    free_o = 1'b0; free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w])    begin dup_o  = 1'b1; dup_way_o  = WAY_W'(w); end
      if (empty[w]) begin free_o = 1'b1; free_way_o = WAY_W'(w); end
    end
  end
endmodule

// File: rtl/spi_sa_table.sv
module spi_sa_table
  import spi_sa_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int WAYS  = 4,
  parameter int SA_W  = 32,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [1:0]       cmd_op_i,
  input  logic [31:0]      cmd_spi_i,
  input  logic [15:0]      cmd_mid_i,
  input  logic [6:0]       cmd_owner_i,
  input  logic             cmd_vld_i,
  input  logic [SA_W-1:0]  cmd_sa_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic [WAY_W-1:0] cmd_way_i,
  output logic             rsp_valid_o,
  output logic [1:0]       rsp_status_o,
  output logic [IDX_W-1:0] rsp_idx_o,
  output logic [WAY_W-1:0] rsp_way_o,
  output logic             rsp_dup_o,
  input  logic             lk_valid_i,
  input  logic [31:0]      lk_spi_i,
  input  logic [15:0]      lk_mid_i,
  input  logic [6:0]       lk_owner_i,
  output logic             lk_done_o,
  output logic             lk_hit_o,
  output logic [WAY_W-1:0] lk_way_o,
  output logic [SA_W-1:0]  lk_sa_o
);
  localparam int SETS = 1 << IDX_W;

  typedef enum logic {ST_IDLE, ST_FLUSH} state_e;

  state_e           st_q;
  logic [IDX_W-1:0] fl_cnt_q;
  logic [OWN_W-1:0] fl_own_q;

  sa_op_e  op;
  logic    fire, flushing;
  sa_key_t req_key;
  logic [KEY_W-1:0] lk_key;

  logic [WAYS-1:0][IDX_W-1:0] hc, hl, c_idx;
  sa_key_t [WAYS-1:0]         ck, lkk;
  logic [WAYS-1:0][SA_W-1:0]  lsa;
  logic [WAYS-1:0]            we, fl_hit, lk_eq;

  logic             dup, free;
  logic [WAY_W-1:0] dup_way, free_way;
  logic             add_wr, del_ok;

  assign op       = sa_op_e'(cmd_op_i);
  assign flushing = (st_q == ST_FLUSH);
  assign fire     = cmd_valid_i && !flushing;
  assign req_key  = '{vld: cmd_vld_i, owner: cmd_owner_i, mid: cmd_mid_i, spi: cmd_spi_i};
  assign lk_key   = {lk_owner_i, lk_mid_i, lk_spi_i};

  spi_sa_hash #(.IDX_W(IDX_W), .WAYS(WAYS)) u_hash_c (
    .key_i(req_key[KEY_W-1:0]), .idx_o(hc)
  );
  spi_sa_hash #(.IDX_W(IDX_W), .WAYS(WAYS)) u_hash_l (
    .key_i(lk_key), .idx_o(hl)
  );

  spi_sa_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
    .keys_i(ck), .req_i(req_key[KEY_W-1:0]),
    .dup_o(dup), .dup_way_o(dup_way), .free_o(free), .free_way_o(free_way)
  );

  assign add_wr = fire && op == OP_ADD && !dup && free;
  assign del_ok = ck[cmd_way_i].owner == cmd_owner_i;

  for (genvar w = 0; w < WAYS; w++) begin : g_bank
    assign c_idx[w]  = flushing ? fl_cnt_q : (op == OP_DEL ? cmd_idx_i : hc[w]);
    assign fl_hit[w] = flushing && ck[w].owner == fl_own_q;
    assign we[w]     = (add_wr && free_way == WAY_W'(w)) ||
                       (fire && op == OP_DEL && cmd_way_i == WAY_W'(w) && del_ok) ||
                       fl_hit[w];
    assign lk_eq[w]  = lkk[w].vld && lkk[w][KEY_W-1:0] == lk_key;

    spi_sa_bank #(.IDX_W(IDX_W), .SA_W(SA_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .c_idx_i (c_idx[w]),
      .c_key_o (ck[w]),
      .l_idx_i (hl[w]),
      .l_key_o (lkk[w]),
      .l_sa_o  (lsa[w]),
      .we_i    (we[w]),
      .w_key_i (add_wr ? req_key : '0),
      .w_sa_i  (add_wr ? cmd_sa_i : '0)
    );
  end

  // command sequencing and response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      fl_cnt_q     <= '0;
      fl_own_q     <= '0;
      rsp_valid_o  <= 1'b0;
      rsp_status_o <= RS_OK;
      rsp_idx_o    <= '0;
      rsp_way_o    <= '0;
      rsp_dup_o    <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (flushing) begin
        fl_cnt_q <= fl_cnt_q + 1'b1;
        if (fl_cnt_q == IDX_W'(SETS - 1)) begin
          st_q         <= ST_IDLE;
          rsp_valid_o  <= 1'b1;
          rsp_status_o <= RS_OK;
          rsp_idx_o    <= '0;
          rsp_way_o    <= '0;
          rsp_dup_o    <= 1'b0;
        end
      end else if (fire) begin
        rsp_status_o <= RS_OK;
        rsp_idx_o    <= '0;
        rsp_way_o    <= '0;
        rsp_dup_o    <= 1'b0;
        unique case (op)
          OP_ADD: begin
            rsp_valid_o <= 1'b1;
            if (dup) begin
              rsp_idx_o <= hc[dup_way];
              rsp_way_o <= dup_way;
              rsp_dup_o <= 1'b1;
            end else if (free) begin
              rsp_idx_o <= hc[free_way];
              rsp_way_o <= free_way;
            end else begin
              rsp_status_o <= RS_FULL;
            end
          end
          OP_DEL: begin
            rsp_valid_o  <= 1'b1;
            rsp_idx_o    <= cmd_idx_i;
            rsp_way_o    <= cmd_way_i;
            rsp_status_o <= del_ok ? RS_OK : RS_NOT_OWNER;
          end
          OP_FLUSH: begin
            st_q     <= ST_FLUSH;
            fl_cnt_q <= '0;
            fl_own_q <= cmd_owner_i;
          end
          default: rsp_valid_o <= 1'b1;
        endcase
      end
    end
  end

  assign cmd_ready_o = !flushing;

  // lookup result, one cycle
  logic             lk_any;
  logic [WAY_W-1:0] lk_w;
  always_comb begin
    lk_any = 1'b0; lk_w = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (lk_eq[w]) begin lk_any = 1'b1; lk_w = WAY_W'(w); end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_done_o <= 1'b0;
      lk_hit_o  <= 1'b0;
      lk_way_o  <= '0;
      lk_sa_o   <= '0;
    end else begin
      lk_done_o <= lk_valid_i;
      lk_hit_o  <= lk_valid_i && lk_any;
      lk_way_o  <= lk_w;
      lk_sa_o   <= lk_any ? lsa[lk_w] : '0;
    end
  end
endmodule

// File: rtl/spi_sa_table_chk.sv
module spi_sa_table_chk #(
  parameter int IDX_W = 9
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       cmd_ready_o,
  input logic [1:0] cmd_op_i,
  input logic       rsp_valid_o,
  input logic [1:0] rsp_status_o,
  input logic       rsp_dup_o,
  input logic       lk_valid_i,
  input logic       lk_done_o,
  input logic       lk_hit_o
);
  localparam int SETS = 1 << IDX_W;

  logic [IDX_W+1:0] low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_cnt <= '0;
    else if (!cmd_ready_o) low_cnt <= low_cnt + 1'b1;
    else                  low_cnt <= '0;
  end

  assert_rsp_next_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && cmd_op_i != 2'd2 |=> rsp_valid_o);

  assert_flush_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && cmd_op_i == 2'd2 |=> !cmd_ready_o && !rsp_valid_o);

  assert_flush_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt <= (IDX_W+2)'(SETS));

  assert_flush_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_ready_o) |-> rsp_valid_o);

  assert_dup_ok_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_dup_o |-> rsp_status_o == 2'd0);

  assert_lk_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_done_o);

  assert_lk_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !lk_done_o && !lk_hit_o);
endmodule

bind spi_sa_table spi_sa_table_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
  .cmd_ready_o(cmd_ready_o), .cmd_op_i(cmd_op_i), .rsp_valid_o(rsp_valid_o),
  .rsp_status_o(rsp_status_o), .rsp_dup_o(rsp_dup_o), .lk_valid_i(lk_valid_i),
  .lk_done_o(lk_done_o), .lk_hit_o(lk_hit_o)
);

// File: tb/sim_spi_sa_table.sv
module sim_spi_sa_table;
  localparam int IW   = 9;
  localparam int SETS = 1 << IW;
  localparam logic [15:0] MID = 16'h00C3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cmd_valid = 0, cmd_vld = 0, lk_valid = 0;
  logic [1:0]  cmd_op = 0, cmd_way = 0;
  logic [31:0] cmd_spi = 0, cmd_sa = 0, lk_spi = 0;
  logic [15:0] cmd_mid = 0, lk_mid = 0;
  logic [6:0]  cmd_owner = 0, lk_owner = 0;
  logic [IW-1:0] cmd_idx = 0;
  logic        cmd_ready, rsp_valid, rsp_dup, lk_done, lk_hit;
  logic [1:0]  rsp_status, rsp_way, lk_way;
  logic [IW-1:0] rsp_idx;
  logic [31:0] lk_sa;

  spi_sa_table #(.IDX_W(IW), .WAYS(4), .SA_W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_spi_i(cmd_spi), .cmd_mid_i(cmd_mid), .cmd_owner_i(cmd_owner),
    .cmd_vld_i(cmd_vld), .cmd_sa_i(cmd_sa), .cmd_idx_i(cmd_idx), .cmd_way_i(cmd_way),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_idx_o(rsp_idx),
    .rsp_way_o(rsp_way), .rsp_dup_o(rsp_dup),
    .lk_valid_i(lk_valid), .lk_spi_i(lk_spi), .lk_mid_i(lk_mid), .lk_owner_i(lk_owner),
    .lk_done_o(lk_done), .lk_hit_o(lk_hit), .lk_way_o(lk_way), .lk_sa_o(lk_sa)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 model: fold of 9-bit slices, rotate left by way
  function automatic logic [IW-1:0] bh(input logic [54:0] k, input int w);
    logic [62:0] e = {8'b0, k};
    logic [IW-1:0] f = '0;
    for (int i = 0; i < 7; i++) f ^= e[i*IW +: IW];
    for (int r = 0; r < w; r++) f = {f[IW-2:0], f[IW-1]};
    return f;
  endfunction

  // collision family: same fold for every j
  function automatic logic [31:0] fspi(input int j);
    return 32'hA500_0000 | 32'(j) | (32'(j) << 9);
  endfunction

  function automatic logic [54:0] mk(input logic [6:0] o, input int j);
    return {o, MID, fspi(j)};
  endfunction

  task automatic cmd(input logic [1:0] op, input logic [54:0] k, input logic v,
                     input logic [31:0] sa, input logic [IW-1:0] idx, input logic [1:0] way);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_owner = k[54:48]; cmd_mid = k[47:32];
    cmd_spi = k[31:0]; cmd_vld = v; cmd_sa = sa; cmd_idx = idx; cmd_way = way;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic look(input logic [54:0] k);
    @(negedge clk);
    lk_valid = 1; lk_owner = k[54:48]; lk_mid = k[47:32]; lk_spi = k[31:0];
    @(negedge clk);
    lk_valid = 0;
  endtask

  // vector: {j[8:0], owner[6:0], sa[31:0], status[1:0], way[1:0], dup}
  localparam int NV = 8;
  localparam logic [52:0] VEC [NV] = '{
    {9'd1, 7'd3, 32'h0000_0100, 2'd0, 2'd0, 1'b0},
    {9'd2, 7'd3, 32'h0000_0200, 2'd0, 2'd1, 1'b0},
    {9'd1, 7'd3, 32'h0000_0999, 2'd0, 2'd0, 1'b1},
    {9'd3, 7'd3, 32'h0000_0300, 2'd0, 2'd2, 1'b0},
    {9'd4, 7'd3, 32'h0000_0400, 2'd0, 2'd3, 1'b0},
    {9'd5, 7'd3, 32'h0000_0500, 2'd1, 2'd0, 1'b0},
    {9'd2, 7'd3, 32'h0000_0777, 2'd0, 2'd1, 1'b1},
    {9'd1, 7'd5, 32'h0000_5100, 2'd0, 2'd0, 1'b0}
  };

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", cmd_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 lk_done", lk_done, 0);
    look(mk(7'd3, 1));
    chk("R1 empty lookup done", lk_done, 1);
    chk("R1 empty lookup miss", lk_hit, 0);

    // R2 R3 R4 R5 R10 vector walk
    for (int v = 0; v < NV; v++) begin
      logic [54:0] k;
      string tag;
      k = mk(VEC[v][43:37], int'(VEC[v][52:44]));
      tag = VEC[v][0] ? "R4" : (VEC[v][4:3] == 2'd1 ? "R5" : (v == 7 ? "R10" : "R3"));
      cmd(2'd0, k, 1'b1, VEC[v][36:5], '0, '0);
      chk({tag, " rsp_valid"}, rsp_valid, 1);
      chk({tag, " status"}, rsp_status, VEC[v][4:3]);
      chk({tag, " way"}, rsp_way, VEC[v][2:1]);
      chk({tag, " dup"}, rsp_dup, VEC[v][0]);
      chk("R2 index", rsp_idx, VEC[v][4:3] == 2'd1 ? '0 : bh(k, int'(VEC[v][2:1])));
    end

    // R4 duplicate did not overwrite; R5 full wrote nothing
    look(mk(7'd3, 1));
    chk("R4 hit", lk_hit, 1);
    chk("R4 sa kept", lk_sa, 32'h100);
    chk("R9 way", lk_way, 0);
    look(mk(7'd3, 5));
    chk("R5 not written", lk_hit, 0);
    look(mk(7'd5, 1));
    chk("R10 other owner sa", lk_sa, 32'h5100);

    // R7 wrong owner delete
    cmd(2'd1, mk(7'd7, 0), 1'b0, 0, bh(mk(7'd3, 1), 0), 2'd0);
    chk("R7 status", rsp_status, 2);
    look(mk(7'd3, 1));
    chk("R7 entry kept", lk_hit, 1);

    // R6 owner delete then reuse
    cmd(2'd1, mk(7'd3, 0), 1'b0, 0, bh(mk(7'd3, 1), 0), 2'd0);
    chk("R6 status", rsp_status, 0);
    look(mk(7'd3, 1));
    chk("R6 cleared", lk_hit, 0);
    cmd(2'd0, mk(7'd3, 5), 1'b1, 32'h555, '0, '0);
    chk("R6 reuse way", rsp_way, 0);
    chk("R6 reuse status", rsp_status, 0);

    // R9 entry written with valid bit clear
    cmd(2'd0, mk(7'd6, 1), 1'b0, 32'h66, '0, '0);
    chk("R9 invalid add way", rsp_way, 0);
    look(mk(7'd6, 1));
    chk("R9 invalid no hit", lk_hit, 0);
    cmd(2'd0, mk(7'd6, 1), 1'b1, 32'h67, '0, '0);
    chk("R9 not dup", rsp_dup, 0);
    chk("R9 same way", rsp_way, 0);
    look(mk(7'd6, 1));
    chk("R9 hit sa", lk_sa, 32'h67);

    // R8 flush owner 3
    begin
      int low = 0;
      cmd(2'd2, mk(7'd3, 0), 1'b0, 0, '0, '0);
      while (!rsp_valid && low < 2 * SETS) begin
        if (!cmd_ready) low++;
        @(negedge clk);
      end
      chk("R8 busy cycles", low, SETS);
      chk("R8 response", rsp_valid, 1);
      chk("R8 ready back", cmd_ready, 1);
    end
    for (int j = 2; j <= 5; j++) begin
      look(mk(7'd3, j));
      chk("R8 owner cleared", lk_hit, 0);
    end
    look(mk(7'd5, 1));
    chk("R8 other owner kept", lk_hit, 1);
    look(mk(7'd6, 1));
    chk("R8 other owner kept 2", lk_sa, 32'h67);
    cmd(2'd0, mk(7'd3, 2), 1'b1, 32'h22, '0, '0);
    chk("R8 set free after flush", rsp_way, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule